// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the purely combinational datapath of a small accumulator-style 8-bit processor whose instructions are 12 bits wide. In a single pass it decodes one instruction word, takes the accumulator value W, the operand fetched from the addressed file register and the current carry, and produces these outputs:

- the 8-bit result;
- where the result goes (accumulator or file register), with one write strobe for each target;
- new carry, digit-carry and zero values, with a three-bit mask saying which of them the instruction updates;
- a skip condition for the conditional-skip instructions.

The surrounding core holds the register file, program counter and status register. It applies the strobes and the flag mask at its own clock edge. Encodings that do not belong to this datapath produce no write, no flag update and no skip. These include control transfer, system and I/O-direction opcodes.

Top module: `byte_alu`

## Requirements
- R1: For file-operand instructions (insn[11:6] is the opcode, insn[5] is d), d=0 sends the result to W (w_we=1, dest_file=0) and d=1 sends it to the file register (f_we=1, dest_file=1). w_we and f_we are never both high. Opcode 000000 with d=1 stores W into the file register. Opcode 000001 clears the destination to zero.
- R2: Add (opcode 000111) gives W+f. C is the carry out of bit 7, DC is the carry out of bit 3, and Z is also set. The mask is 3'b111 (bit0=C, bit1=DC, bit2=Z).
- R3: Subtract (opcode 000010) gives f−W. C=1 when there is no borrow (f≥W). DC=1 when there is no borrow from the low nibble. The mask is 3'b111.
- R4: The bitwise forms OR, AND and XOR update Z only (mask 3'b100). The file forms are opcodes 000100, 000101 and 000110 and combine f with W. The literal forms are insn[11:8] = 1101, 1110 and 1111 and combine W with insn[7:0]. The literal forms always write W.
- R5: Rotate right (001100) gives {c_in, f[7:1]} with C=f[0]. Rotate left (001101) gives {f[6:0], c_in} with C=f[7]. Both have mask 3'b001.
- R6: These opcodes update Z only:

  | Operation | Opcode | Result |
  |---|---|---|
  | Move | 001000 | f |
  | Complement | 001001 | ~f |
  | Increment | 001010 | f+1 |
  | Decrement | 000011 | f−1 |
  | Clear | 000001 | 0 |

- R7: These instructions update no flags (mask 3'b000):

  | Instruction | Encoding | Effect |
  |---|---|---|
  | Nibble swap | 001110 | {f[3:0], f[7:4]} |
  | Load literal | insn[11:8]=1100 | insn[7:0] to W |
  | Store W | 000000 with d=1 | W to f |
  | Bit clear | insn[11:8]=0100 | f with bit insn[7:5] forced to 0, written to f |
  | Bit set | insn[11:8]=0101 | f with bit insn[7:5] forced to 1, written to f |

- R8: Decrement-and-skip (001011) and increment-and-skip (001111) write f∓1 to the destination and assert skip when that result is zero. Their mask is 3'b000.
- R9: Bit test with insn[11:8]=0110 skips when f[insn[7:5]] is 0. Bit test with insn[11:8]=0111 skips when that bit is 1. Neither one writes or updates flags.
- R10: When mask bit2 is set, z_out is 1 exactly when the 8-bit result is zero.
- R11: A flag output whose mask bit is clear reads 0.
- R12: All other encodings give no write, mask 3'b000 and no skip. These are insn[11:8] = 1000, 1001, 1010 and 1011, and opcode 000000 with d=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 12 | Instruction word |
| w_in | input | 8 | Accumulator value |
| f_in | input | 8 | Addressed file-register operand |
| c_in | input | 1 | Current carry flag |
| result | output | 8 | Computed byte |
| dest_file | output | 1 | 1 = result targets the file register, 0 = W |
| w_we | output | 1 | Write strobe for W |
| f_we | output | 1 | Write strobe for the file register |
| flag_upd | output | 3 | Update mask: bit0 C, bit1 DC, bit2 Z |
| c_out | output | 1 | New carry |
| dc_out | output | 1 | New digit carry |
| z_out | output | 1 | New zero flag |
| skip | output | 1 | Skip the next instruction |

## Verification
The assertions are immediate checks inside the top module. They assume all inputs have settled to known values whenever the combinational logic is evaluated, and the bench never drives X or Z onto them. Any 12-bit pattern is legal, so the sweeps cover three sets of inputs:
- every value of insn[11:5], with the low bits varied;
- a coarse grid of W and f values, including both 0x00 and 0xFF;
- both carry values.

Add and subtract are swept over every W/f pair, so every carry and digit-carry boundary is reached.

// File: rtl/byte_alu_pkg.sv
// Package: shared operation codes and flag-mask positions for the byte ALU.
// Assumes an 8-bit datapath and the fixed 12-bit instruction layout.
package byte_alu_pkg;

    localparam int DATA_W  = 8;
    localparam int INSN_W  = 12;
    localparam int NIB_W   = DATA_W / 2;
    localparam int BIDX_W  = $clog2(DATA_W);
    localparam int FLAG_W  = 3;

    // Positions inside the flag update mask
    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;

    typedef enum logic [4:0] {
        OP_NONE,
        OP_PASS_B,   // result = second operand (W or literal)
        OP_CLR,
        OP_SUB,
        OP_DEC,
        OP_IOR,
        OP_AND,
        OP_XOR,
        OP_ADD,
        OP_MOV,
        OP_COM,
        OP_INC,
        OP_DEC_SKZ,
        OP_ROT_R,
        OP_ROT_L,
        OP_SWAP,
        OP_INC_SKZ,
        OP_BIT_CLR,
        OP_BIT_SET,
        OP_TST_CLR,
        OP_TST_SET
    } alu_op_e;

endpackage

// File: rtl/byte_alu_decode.sv
// Decoder: turns a 12-bit instruction word into an operation, operand
// selection, destination, write request and flag update mask.
// Assumes the word is stable while the datapath evaluates.
module byte_alu_decode
    import byte_alu_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output alu_op_e           op,
    output logic              use_lit,
    output logic              to_file,
    output logic              wr_req,
    output logic [FLAG_W-1:0] mask
);

    localparam logic [FLAG_W-1:0] M_NONE = 3'b000;
    localparam logic [FLAG_W-1:0] M_C    = 3'b001;
    localparam logic [FLAG_W-1:0] M_Z    = 3'b100;
    localparam logic [FLAG_W-1:0] M_ALL  = 3'b111;

    logic [5:0] opc6;
    logic [3:0] opc4;
    logic       dbit;

    assign opc6 = insn[11:6];
    assign opc4 = insn[11:8];
    assign dbit = insn[5];

    // Purpose: map the instruction encoding onto controls
    always_comb begin
        op      = OP_NONE;
        use_lit = 1'b0;
        to_file = 1'b0;
        wr_req  = 1'b0;
        mask    = M_NONE;
        if (opc4[3:2] == 2'b00) begin
            to_file = dbit;
            wr_req  = 1'b1;
            unique case (opc6)
                6'b000000: begin
                    op      = dbit ? OP_PASS_B : OP_NONE;
                    wr_req  = dbit;
                end
                6'b000001: begin op = OP_CLR;     mask = M_Z;   end
                6'b000010: begin op = OP_SUB;     mask = M_ALL; end
                6'b000011: begin op = OP_DEC;     mask = M_Z;   end
                6'b000100: begin op = OP_IOR;     mask = M_Z;   end
                6'b000101: begin op = OP_AND;     mask = M_Z;   end
                6'b000110: begin op = OP_XOR;     mask = M_Z;   end
                6'b000111: begin op = OP_ADD;     mask = M_ALL; end
                6'b001000: begin op = OP_MOV;     mask = M_Z;   end
                6'b001001: begin op = OP_COM;     mask = M_Z;   end
                6'b001010: begin op = OP_INC;     mask = M_Z;   end
                6'b001011: begin op = OP_DEC_SKZ;               end
                6'b001100: begin op = OP_ROT_R;   mask = M_C;   end
                6'b001101: begin op = OP_ROT_L;   mask = M_C;   end
                6'b001110: begin op = OP_SWAP;                  end
                default:   begin op = OP_INC_SKZ;               end
            endcase
        end else begin
            unique case (opc4)
                4'b0100: begin op = OP_BIT_CLR; to_file = 1'b1; wr_req = 1'b1; end
                4'b0101: begin op = OP_BIT_SET; to_file = 1'b1; wr_req = 1'b1; end
                4'b0110: begin op = OP_TST_CLR; end
                4'b0111: begin op = OP_TST_SET; end
                4'b1100: begin op = OP_PASS_B; use_lit = 1'b1; wr_req = 1'b1; end
                4'b1101: begin op = OP_IOR; use_lit = 1'b1; wr_req = 1'b1; mask = M_Z; end
                4'b1110: begin op = OP_AND; use_lit = 1'b1; wr_req = 1'b1; mask = M_Z; end
                4'b1111: begin op = OP_XOR; use_lit = 1'b1; wr_req = 1'b1; mask = M_Z; end
                default: begin op = OP_NONE; end
            endcase
        end
    end

endmodule

// File: rtl/byte_alu_exec.sv
// Execution unit: computes the result byte, raw carry and digit carry and
// the selected bit of the file operand. Flags are not gated here.
// Assumes b_opnd is already W or the literal, as the decoder chose.
module byte_alu_exec
    import byte_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] f_opnd,
    input  logic [DATA_W-1:0] b_opnd,
    input  logic [BIDX_W-1:0] bidx,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_raw,
    output logic              dc_raw,
    output logic              bit_val
);

    logic [DATA_W:0]       add_full, sub_full;
    logic [NIB_W:0]        add_low, sub_low;
    logic [DATA_W-1:0]     onehot;

    // Purpose: full-width and low-nibble adders for add and subtract
    always_comb begin
        add_full = {1'b0, f_opnd} + {1'b0, b_opnd};
        sub_full = {1'b0, f_opnd} + {1'b0, ~b_opnd} + {{DATA_W{1'b0}}, 1'b1};
        add_low  = {1'b0, f_opnd[NIB_W-1:0]} + {1'b0, b_opnd[NIB_W-1:0]};
        sub_low  = {1'b0, f_opnd[NIB_W-1:0]} + {1'b0, ~b_opnd[NIB_W-1:0]}
                   + {{NIB_W{1'b0}}, 1'b1};
        onehot   = {{(DATA_W-1){1'b0}}, 1'b1} << bidx;
        bit_val  = |(f_opnd & onehot);
    end

    // Purpose: select the result and raw carries per operation
    always_comb begin
        res    = '0;
        c_raw  = 1'b0;
        dc_raw = 1'b0;
        unique case (op)
            OP_PASS_B:  res = b_opnd;
            OP_CLR:     res = '0;
            OP_SUB:     begin res = sub_full[DATA_W-1:0]; c_raw = sub_full[DATA_W]; dc_raw = sub_low[NIB_W]; end
            OP_ADD:     begin res = add_full[DATA_W-1:0]; c_raw = add_full[DATA_W]; dc_raw = add_low[NIB_W]; end
            OP_DEC,
            OP_DEC_SKZ: res = f_opnd - {{(DATA_W-1){1'b0}}, 1'b1};
            OP_INC,
            OP_INC_SKZ: res = f_opnd + {{(DATA_W-1){1'b0}}, 1'b1};
            OP_IOR:     res = f_opnd | b_opnd;
            OP_AND:     res = f_opnd & b_opnd;
            OP_XOR:     res = f_opnd ^ b_opnd;
            OP_MOV:     res = f_opnd;
            OP_COM:     res = ~f_opnd;
            OP_ROT_R:   begin res = {c_in, f_opnd[DATA_W-1:1]}; c_raw = f_opnd[0]; end
            OP_ROT_L:   begin res = {f_opnd[DATA_W-2:0], c_in}; c_raw = f_opnd[DATA_W-1]; end
            OP_SWAP:    res = {f_opnd[NIB_W-1:0], f_opnd[DATA_W-1:NIB_W]};
            OP_BIT_CLR: res = f_opnd & ~onehot;
            OP_BIT_SET: res = f_opnd | onehot;
            OP_TST_CLR,
            OP_TST_SET: res = f_opnd;
            default:    res = '0;
        endcase
    end

endmodule

// File: rtl/byte_alu.sv
// Top: combinational byte ALU. Decodes the instruction, evaluates the
// operation, gates flags by the update mask and forms write strobes and
// the skip condition. Assumes the core applies the strobes and mask at its
// own clock edge. For literal forms the file operand stands for W.
module byte_alu
    import byte_alu_pkg::*;
(
    input  logic [11:0] insn,
    input  logic [7:0]  w_in,
    input  logic [7:0]  f_in,
    input  logic        c_in,
    output logic [7:0]  result,
    output logic        dest_file,
    output logic        w_we,
    output logic        f_we,
    output logic [2:0]  flag_upd,
    output logic        c_out,
    output logic        dc_out,
    output logic        z_out,
    output logic        skip
);

    alu_op_e           op;
    logic              use_lit, to_file, wr_req;
    logic [FLAG_W-1:0] mask;
    logic [DATA_W-1:0] f_sel, b_sel, res;
    logic              c_raw, dc_raw, bit_val;

    byte_alu_decode u_dec (
        .insn    (insn),
        .op      (op),
        .use_lit (use_lit),
        .to_file (to_file),
        .wr_req  (wr_req),
        .mask    (mask)
    );

    // Purpose: literal forms combine W with the literal field
    always_comb begin
        f_sel = use_lit ? w_in : f_in;
        b_sel = use_lit ? insn[7:0] : w_in;
    end

    byte_alu_exec u_exe (
        .op      (op),
        .f_opnd  (f_sel),
        .b_opnd  (b_sel),
        .bidx    (insn[7:5]),
        .c_in    (c_in),
        .res     (res),
        .c_raw   (c_raw),
        .dc_raw  (dc_raw),
        .bit_val (bit_val)
    );

    // Purpose: drive outputs, gating flags by the update mask
    always_comb begin
        result    = res;
        dest_file = to_file;
        w_we      = wr_req & ~to_file;
        f_we      = wr_req & to_file;
        flag_upd  = mask;
        c_out     = mask[FLG_C]  & c_raw;
        dc_out    = mask[FLG_DC] & dc_raw;
        z_out     = mask[FLG_Z]  & (res == '0);
        unique case (op)
            OP_DEC_SKZ, OP_INC_SKZ: skip = (res == '0);
            OP_TST_CLR:             skip = ~bit_val;
            OP_TST_SET:             skip = bit_val;
            default:                skip = 1'b0;
        endcase
    end

    // Purpose: structural checks across decoder, execution unit and outputs
    always_comb begin
        assert_single_target_R1: assert (!(w_we && f_we));
        assert_strobe_matches_target_R1: assert (!f_we || dest_file);
        assert_skip_keeps_flags_R8: assert (!skip || (flag_upd == 3'b000));
        assert_skip_write_zero_R8: assert (!(skip && (w_we || f_we)) || (result == 8'h00));
        assert_rotate_carry_src_R5: assert (flag_upd != 3'b001 || c_out == f_in[7] || c_out == f_in[0]);
        assert_flags_need_write_R12: assert (flag_upd == 3'b000 || w_we || f_we);
    end

endmodule

// File: tb/sim_byte_alu.sv
// Bench: sweeps instruction patterns and operand grids, with expected
// values computed arithmetically from the requirements.
module sim_byte_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic [11:0] insn = '0;
    logic [7:0]  w_in = '0, f_in = '0;
    logic        c_in = 1'b0;
    logic [7:0]  result;
    logic        dest_file, w_we, f_we, c_out, dc_out, z_out, skip;
    logic [2:0]  flag_upd;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_alu u0 (
        .insn(insn), .w_in(w_in), .f_in(f_in), .c_in(c_in),
        .result(result), .dest_file(dest_file), .w_we(w_we), .f_we(f_we),
        .flag_upd(flag_upd), .c_out(c_out), .dc_out(dc_out), .z_out(z_out),
        .skip(skip)
    );

    task automatic report(input string req, input string what,
                          input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s insn=%03h w=%02h f=%02h c=%0b actual=%0h expected=%0h",
                     req, what, insn, w_in, f_in, c_in, act, exp);
        end
    endtask

    task automatic run(input logic [11:0] ins, input logic [7:0] w,
                       input logic [7:0] f, input logic c);
        logic [7:0] e_res = 8'h00;
        logic [2:0] e_msk = 3'b000;
        logic       e_c = 1'b0, e_dc = 1'b0, e_skip = 1'b0;
        logic       e_wr = 1'b0, e_file = 1'b0;
        logic       d = ins[5];
        logic [2:0] b = ins[7:5];
        logic [7:0] k = ins[7:0];
        string      req = "R12";
        insn = ins; w_in = w; f_in = f; c_in = c;
        if (ins[11:10] == 2'b00 && ins[9:8] != 2'b00 || ins[11:8] == 4'b0000 ||
            ins[11:8] == 4'b0001 || ins[11:8] == 4'b0010 || ins[11:8] == 4'b0011) begin
            e_wr = 1'b1; e_file = d;
            case (ins[11:6])
                6'd0:  begin req = d ? "R7" : "R12"; e_wr = d; e_res = w; end
                6'd1:  begin req = "R6"; e_res = 0; e_msk = 3'b100; end
                6'd2:  begin req = "R3"; e_res = f - w; e_msk = 3'b111;
                             e_c = (f >= w); e_dc = (f[3:0] >= w[3:0]); end
                6'd3:  begin req = "R6"; e_res = f - 1; e_msk = 3'b100; end
                6'd4:  begin req = "R4"; e_res = f | w; e_msk = 3'b100; end
                6'd5:  begin req = "R4"; e_res = f & w; e_msk = 3'b100; end
                6'd6:  begin req = "R4"; e_res = f ^ w; e_msk = 3'b100; end
                6'd7:  begin req = "R2"; e_res = f + w; e_msk = 3'b111;
                             e_c = (int'(f) + int'(w)) > 255;
                             e_dc = (int'(f[3:0]) + int'(w[3:0])) > 15; end
                6'd8:  begin req = "R6"; e_res = f; e_msk = 3'b100; end
                6'd9:  begin req = "R6"; e_res = 8'(255 - int'(f)); e_msk = 3'b100; end
                6'd10: begin req = "R6"; e_res = f + 1; e_msk = 3'b100; end
                6'd11: begin req = "R8"; e_res = f - 1; e_skip = (f == 8'd1); end
                6'd12: begin req = "R5"; e_res = 8'(int'(f) / 2 + (c ? 128 : 0));
                             e_c = f[0]; e_msk = 3'b001; end
                6'd13: begin req = "R5"; e_res = 8'(int'(f) * 2 + (c ? 1 : 0));
                             e_c = f[7]; e_msk = 3'b001; end
                6'd14: begin req = "R7"; e_res = 8'((int'(f) % 16) * 16 + int'(f) / 16); end
                default: begin req = "R8"; e_res = f + 1; e_skip = (f == 8'hFF); end
            endcase
        end else begin
            case (ins[11:8])
                4'b0100: begin req = "R7"; e_wr = 1; e_file = 1;
                               e_res = f & ~(8'd1 << b); end
                4'b0101: begin req = "R7"; e_wr = 1; e_file = 1;
                               e_res = f | (8'd1 << b); end
                4'b0110: begin req = "R9"; e_skip = ((f >> b) & 8'd1) == 0; end
                4'b0111: begin req = "R9"; e_skip = ((f >> b) & 8'd1) == 1; end
                4'b1100: begin req = "R7"; e_wr = 1; e_res = k; end
                4'b1101: begin req = "R4"; e_wr = 1; e_res = w | k; e_msk = 3'b100; end
                4'b1110: begin req = "R4"; e_wr = 1; e_res = w & k; e_msk = 3'b100; end
                4'b1111: begin req = "R4"; e_wr = 1; e_res = w ^ k; e_msk = 3'b100; end
                default: req = "R12";
            endcase
        end
        #1;
        report(req, "mask", 16'(flag_upd), 16'(e_msk));
        report(e_wr ? "R1" : req, "strobes", 16'({w_we, f_we}),
               16'({e_wr & ~e_file, e_wr & e_file}));
        if (e_wr) report(req, "result", 16'(result), 16'(e_res));
        report(e_msk[0] ? req : "R11", "carry", 16'(c_out), 16'(e_c));
        report(e_msk[1] ? req : "R11", "dcarry", 16'(dc_out), 16'(e_dc));
        report(e_msk[2] ? "R10" : "R11", "zero", 16'(z_out),
               16'(e_msk[2] && e_res == 8'h00));
        report(req, "skip", 16'(skip), 16'(e_skip));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > WATCHDOG_CYCLES) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Idle word: no write, no flags, no skip (R12)
        run(12'h000, 8'h5A, 8'hA5, 1'b1);
        // Exhaustive add and subtract over every W/f pair (R2, R3)
        for (int w = 0; w < 256; w++) begin
            for (int f = 0; f < 256; f++) begin
                run({6'b000111, 1'(w ^ f), 5'h03}, 8'(w), 8'(f), 1'(f >> 1));
                run({6'b000010, 1'(w ^ f), 5'h07}, 8'(w), 8'(f), 1'(w >> 1));
            end
        end
        // Every upper 7-bit pattern over an operand grid (all requirements)
        for (int hi = 0; hi < 128; hi++) begin
            for (int w = 0; w < 256; w += 15) begin
                for (int f = 0; f < 256; f += 17) begin
                    for (int c = 0; c < 2; c++) begin
                        run({7'(hi), 5'(hi + w)}, 8'(w), 8'(f), 1'(c));
                    end
                end
            end
        end
        // Skip boundaries on exact wrap values (R8)
        run(12'b001011_1_00001, 8'h00, 8'h01, 1'b0);
        run(12'b001111_0_00001, 8'h00, 8'hFF, 1'b0);
        run(12'b001111_0_00001, 8'h00, 8'hFE, 1'b0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule